// File: doc/BRIEF.md
# Multiplexed Hexadecimal Display Scanner

This block drives a row of six common-cathode seven-segment digits that share one set of segment lines. A free-running prescaler produces a periodic step pulse. A six-stage one-hot ring advances on that pulse and pulls exactly one cathode low. The same one-hot vector picks the 4-bit nibble of a 24-bit display value that belongs to the lit digit. A lookup table inside the block turns that nibble into a full hexadecimal glyph, so all sixteen values from 0 to F are shown correctly. Persistence of vision then makes the six digits appear steady.

The displayed value comes from one of two sources. The first is an internal 24-bit up-counter that advances once per scan step. The second is an external 24-bit input, for example a 16-bit address on the four leftmost digits and a data byte on the two rightmost. A wiring-check mode slows the scan by a much larger division. In that mode each digit lights a fixed set of segments, so a miswired segment or cathode line is easy to see.

With the defaults at a 7.37 MHz clock, the scan step is every 1024 cycles (about 7 kHz) and the test step is every 2^20 cycles (about 7 Hz).

Top module: `hexscan_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the ring loads digit 1 active (`cath_n_o` = 6'b111110), and the prescaler and internal counter clear. With `src_sel` = 0 and `test_mode` = 0 after reset, `seg_o` = 7'h3F and `dp_o` = 0.
- R2: After reset, exactly one bit of `cath_n_o` is low in every cycle.
- R3: With `test_mode` = 0, the ring advances once every 2^SCAN_DIV_W cycles after reset. The low cathode moves from bit i to bit i+1, and bit 5 wraps to bit 0. Between steps it holds.
- R4: When cathode bit k (digit k+1) is low, the decoded nibble is value[23-4k:20-4k]. Digit 1 (bit 0) is the leftmost and shows bits 23:20. Digit 6 (bit 5) shows bits 3:0.
- R5: `seg_o` bit order is g,f,e,d,c,b,a (bit 6 down to bit 0), active high. Nibbles 0 to F decode to 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71.
- R6: With `src_sel` = 0, the displayed value is the internal counter. The counter increments by one on each scan step taken while `test_mode` = 0.
- R7: With `src_sel` = 1, the displayed value is `ext_value` in the same cycle.
- R8: With `test_mode` = 1, the ring advances once every 2^TEST_DIV_W cycles, counted on the shared free-running prescaler. Digits 1 to 6 show 7'h03 (a,b), 7'h04 (c), 7'h08 (d), 7'h10 (e), 7'h20 (f) and 7'h40 (g). `dp_o` is 1 only while digit 6 is lit.
- R9: With `test_mode` = 0, `dp_o` is 0.
- R10: The internal counter holds its value while `test_mode` = 1 and resumes counting from it afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| test_mode | input | 1 | 1 = slow wiring-check pattern, 0 = normal scan |
| src_sel | input | 1 | 0 = internal counter, 1 = external value |
| ext_value | input | 24 | External value to display |
| seg_o | output | 7 | Segment drives, g..a, active high |
| dp_o | output | 1 | Decimal point drive, active high |
| cath_n_o | output | 6 | Digit cathode enables, active low, bit 0 = digit 1 |

## Verification
The bench builds the block with SCAN_DIV_W = 3 and TEST_DIV_W = 5, so a scan step comes every 8 cycles and a test step every 32 cycles. Many full ring rotations in both modes, and switches between the modes at arbitrary prescaler phases, therefore fit in a few thousand cycles. The internal counter moves far enough to exercise several nibbles. Random external values reach every glyph on every digit position.

// File: rtl/hexscan_pkg.sv
`timescale 1ns/1ps
// hexscan_pkg: shared widths, types and the wiring-check pattern for the
// hexadecimal display scanner. Assumes 4-bit nibbles and 7 segments.
package hexscan_pkg;

    localparam int NIB_W = 4;
    localparam int SEG_W = 7;

    typedef logic [SEG_W-1:0] seg_t;

    typedef enum logic {
        SRC_COUNT = 1'b0,
        SRC_EXT   = 1'b1
    } src_e;

    // Fixed wiring-check pattern for digit position idx (0 = leftmost).
    function automatic seg_t check_pattern(input int idx, input int last);
        seg_t pat;
        pat = '0;
        if (idx == last) begin
            pat[6] = 1'b1;
        end else if (idx == 0) begin
            pat[1:0] = 2'b11;
        end else if (idx + 1 < SEG_W) begin
            pat[idx+1] = 1'b1;
        end
        return pat;
    endfunction

endpackage

// File: rtl/hexscan_prescale.sv
`timescale 1ns/1ps
// hexscan_prescale: free-running binary divider. It raises scan_tick once
// every 2^SCAN_DIV_W cycles and test_tick once every 2^TEST_DIV_W cycles.
// Assumes TEST_DIV_W >= SCAN_DIV_W >= 1.
module hexscan_prescale #(
    parameter int SCAN_DIV_W = 10,
    parameter int TEST_DIV_W = 20
) (
    input  logic clk,
    input  logic rst_n,
    output logic scan_tick,
    output logic test_tick
);

    logic [TEST_DIV_W-1:0] div_q;

    // Divider count, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // Terminal counts of the short and long division.
    always_comb begin
        scan_tick = &div_q[SCAN_DIV_W-1:0];
        test_tick = &div_q;
    end

endmodule

// File: rtl/hexscan_ring.sv
`timescale 1ns/1ps
// hexscan_ring: one-hot circular shift register of NUM_DIGITS stages.
// Reset loads stage 0 set. Each step moves the set bit up by one, and
// the top stage feeds stage 0.
module hexscan_ring #(
    parameter int NUM_DIGITS = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step,
    output logic [NUM_DIGITS-1:0] ring_q
);

    localparam logic [NUM_DIGITS-1:0] RING_INIT = NUM_DIGITS'(1);

    // Rotate the one-hot selector on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_q <= RING_INIT;
        end else if (step) begin
            ring_q <= {ring_q[NUM_DIGITS-2:0], ring_q[NUM_DIGITS-1]};
        end
    end

endmodule

// File: rtl/hexscan_glyph.sv
`timescale 1ns/1ps
// hexscan_glyph: combinational nibble to seven-segment hexadecimal glyph.
// Output order is g,f,e,d,c,b,a, active high.
module hexscan_glyph
    import hexscan_pkg::*;
(
    input  logic [NIB_W-1:0] nib,
    output seg_t             seg
);

    // Glyph lookup for all sixteen values.
    always_comb begin
        unique case (nib)
            4'h0: seg = 7'h3F;
            4'h1: seg = 7'h06;
            4'h2: seg = 7'h5B;
            4'h3: seg = 7'h4F;
            4'h4: seg = 7'h66;
            4'h5: seg = 7'h6D;
            4'h6: seg = 7'h7D;
            4'h7: seg = 7'h07;
            4'h8: seg = 7'h7F;
            4'h9: seg = 7'h6F;
            4'hA: seg = 7'h77;
            4'hB: seg = 7'h7C;
            4'hC: seg = 7'h39;
            4'hD: seg = 7'h5E;
            4'hE: seg = 7'h79;
            default: seg = 7'h71;
        endcase
    end

endmodule

// File: rtl/hexscan_top.sv
`timescale 1ns/1ps
// hexscan_top: multiplexed hexadecimal display scanner. A prescaler steps a
// one-hot ring that drives active-low cathodes. The same ring selects the
// nibble of the shown value (internal counter or external input), which is
// decoded to a glyph. Test mode uses the slow tick and fixed patterns.
// Assumes the digit on ring stage 0 is the leftmost (most significant).
module hexscan_top
    import hexscan_pkg::*;
#(
    parameter int NUM_DIGITS = 6,
    parameter int SCAN_DIV_W = 10,
    parameter int TEST_DIV_W = 20
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        test_mode,
    input  logic                        src_sel,
    input  logic [NUM_DIGITS*NIB_W-1:0] ext_value,
    output logic [SEG_W-1:0]            seg_o,
    output logic                        dp_o,
    output logic [NUM_DIGITS-1:0]       cath_n_o
);

    localparam int VAL_W = NUM_DIGITS * NIB_W;

    logic             scan_tick;
    logic             test_tick;
    logic             step_tick;
    logic [NUM_DIGITS-1:0] ring_q;
    logic [VAL_W-1:0] cnt_q;
    logic [VAL_W-1:0] shown;
    logic [NIB_W-1:0] nib_sel;
    seg_t             glyph_seg;
    seg_t             check_seg;
    src_e             src;

    hexscan_prescale #(
        .SCAN_DIV_W (SCAN_DIV_W),
        .TEST_DIV_W (TEST_DIV_W)
    ) u_prescale (
        .clk       (clk),
        .rst_n     (rst_n),
        .scan_tick (scan_tick),
        .test_tick (test_tick)
    );

    // Pick the step source for the ring from the mode.
    always_comb begin
        step_tick = test_mode ? test_tick : scan_tick;
    end

    hexscan_ring #(
        .NUM_DIGITS (NUM_DIGITS)
    ) u_ring (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step_tick),
        .ring_q (ring_q)
    );

    // Internal up-counter, advanced on normal-mode scan steps only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (scan_tick && !test_mode) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Choose the displayed value.
    always_comb begin
        src   = src_e'(src_sel);
        shown = (src == SRC_EXT) ? ext_value : cnt_q;
    end

    // Nibble and check-pattern selection by the one-hot ring.
    always_comb begin
        nib_sel   = '0;
        check_seg = '0;
        for (int i = 0; i < NUM_DIGITS; i++) begin
            if (ring_q[i]) begin
                nib_sel   = nib_sel | shown[(NUM_DIGITS-1-i)*NIB_W +: NIB_W];
                check_seg = check_seg | check_pattern(i, NUM_DIGITS-1);
            end
        end
    end

    hexscan_glyph u_glyph (
        .nib (nib_sel),
        .seg (glyph_seg)
    );

    // Drive the pins.
    always_comb begin
        seg_o    = test_mode ? check_seg : glyph_seg;
        dp_o     = test_mode & ring_q[NUM_DIGITS-1];
        cath_n_o = ~ring_q;
    end

endmodule

// File: rtl/hexscan_checker.sv
`timescale 1ns/1ps
// hexscan_checker: protocol assertions for hexscan_top, attached by bind.
// Observes the pins plus the step pulses and the internal counter.
module hexscan_checker #(
    parameter int NUM_DIGITS = 6,
    parameter int VAL_W      = 24
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  test_mode,
    input logic                  scan_tick,
    input logic                  step_tick,
    input logic [VAL_W-1:0]      cnt_q,
    input logic                  dp_o,
    input logic [NUM_DIGITS-1:0] cath_n_o
);

    // R2: exactly one digit enabled
    assert_one_digit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cath_n_o) == 1);

    // R3: a step rotates the enable one place up
    assert_ring_rotate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step_tick |=> cath_n_o == {$past(cath_n_o[NUM_DIGITS-2:0]), $past(cath_n_o[NUM_DIGITS-1])});

    // R3: without a step the enable holds
    assert_ring_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !step_tick |=> $stable(cath_n_o));

    // R6: counter advances by one on a normal-mode scan step
    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_tick && !test_mode) |=> cnt_q == $past(cnt_q) + 1'b1);

    // R10: counter holds in test mode
    assert_count_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |=> $stable(cnt_q));

    // R9: no decimal point in normal mode
    assert_dp_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |-> !dp_o);

    // R8: decimal point follows the last digit in test mode
    assert_dp_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |-> (dp_o == !cath_n_o[NUM_DIGITS-1]));

endmodule

bind hexscan_top hexscan_checker #(
    .NUM_DIGITS (NUM_DIGITS),
    .VAL_W      (NUM_DIGITS*4)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_mode (test_mode),
    .scan_tick (scan_tick),
    .step_tick (step_tick),
    .cnt_q     (cnt_q),
    .dp_o      (dp_o),
    .cath_n_o  (cath_n_o)
);

// File: tb/hexscan_top_bench.sv
`timescale 1ns/1ps
module hexscan_top_bench;

    localparam int ND     = 6;
    localparam int SW     = 3;
    localparam int TW     = 5;
    localparam int VW     = ND * 4;
    localparam logic [TW-1:0] SMASK = TW'((1 << SW) - 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          test_mode;
    logic          src_sel;
    logic [VW-1:0] ext_value;
    logic [6:0]    seg_o;
    logic          dp_o;
    logic [ND-1:0] cath_n_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    hexscan_top #(
        .NUM_DIGITS (ND),
        .SCAN_DIV_W (SW),
        .TEST_DIV_W (TW)
    ) u_hexscan_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .test_mode (test_mode),
        .src_sel   (src_sel),
        .ext_value (ext_value),
        .seg_o     (seg_o),
        .dp_o      (dp_o),
        .cath_n_o  (cath_n_o)
    );

    // Reference state derived from the requirements.
    logic [TW-1:0] m_pre;
    int            m_idx;
    logic [VW-1:0] m_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre <= '0;
            m_idx <= 0;
            m_cnt <= '0;
        end else begin
            m_pre <= m_pre + 1'b1;
            if (test_mode ? (m_pre == '1) : ((m_pre & SMASK) == SMASK))
                m_idx <= (m_idx == ND-1) ? 0 : m_idx + 1;
            if (!test_mode && ((m_pre & SMASK) == SMASK))
                m_cnt <= m_cnt + 1'b1;
        end
    end

    function automatic logic [6:0] exp_glyph(input logic [3:0] n);
        logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                               7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
        return t[n];
    endfunction

    function automatic logic [6:0] exp_check(input int idx);
        logic [6:0] t [6] = '{7'h03, 7'h04, 7'h08, 7'h10, 7'h20, 7'h40};
        return t[idx];
    endfunction

    function automatic logic [6:0] exp_seg(input int idx, input logic tm,
                                           input logic ss, input logic [VW-1:0] ev,
                                           input logic [VW-1:0] cv);
        logic [VW-1:0] v;
        v = ss ? ev : cv;
        if (tm) return exp_check(idx);
        return exp_glyph(v[(ND-1-idx)*4 +: 4]);
    endfunction

    task automatic check_now();
        logic [ND-1:0] ec;
        logic [6:0]    es;
        logic          ed;
        string         tag;
        ec = ~(ND'(1) << m_idx);
        es = exp_seg(m_idx, test_mode, src_sel, ext_value, m_cnt);
        ed = test_mode && (m_idx == ND-1);
        // R2 R3 R8: cathode position
        checks++;
        if (cath_n_o !== ec) begin
            errors++;
            $display("FAIL %s cathodes actual %b expected %b",
                     test_mode ? "R8" : "R2/R3", cath_n_o, ec);
        end
        // R4 R5 R6 R7 R8 R10: segment pattern
        tag = test_mode ? "R8" : (src_sel ? "R7/R4/R5" : "R6/R10/R4/R5");
        checks++;
        if (seg_o !== es) begin
            errors++;
            $display("FAIL %s segments actual %h expected %h", tag, seg_o, es);
        end
        // R8 R9: decimal point
        checks++;
        if (dp_o !== ed) begin
            errors++;
            $display("FAIL %s dp actual %b expected %b",
                     test_mode ? "R8" : "R9", dp_o, ed);
        end
    endtask

    task automatic check_reset();
        // R1: reset state at the pins
        checks++;
        if (cath_n_o !== 6'b111110 || seg_o !== 7'h3F || dp_o !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset actual %b/%h/%b expected 111110/3f/0",
                     cath_n_o, seg_o, dp_o);
        end
    endtask

    task automatic run(input int n, input int rnd_ext, input int rnd_mode);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_now();
            if (rnd_ext != 0 && ($urandom % 3) == 0) ext_value = VW'($urandom);
            if (rnd_mode != 0 && ($urandom % 97) == 0) test_mode = ~test_mode;
            if (rnd_mode != 0 && ($urandom % 41) == 0) src_sel = ~src_sel;
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst_n     = 1'b0;
        test_mode = 1'b0;
        src_sel   = 1'b0;
        ext_value = '0;
        repeat (4) @(negedge clk);
        check_reset();
        rst_n = 1'b1;

        // R6: internal counter display across many steps
        run(700, 0, 0);

        // R7 R4 R5: directed external values covering all glyphs
        src_sel   = 1'b1;
        ext_value = 24'h012345;
        run(60, 0, 0);
        ext_value = 24'h6789AB;
        run(60, 0, 0);
        ext_value = 24'hCDEF10;
        run(60, 0, 0);
        run(600, 1, 0);

        // R8: wiring-check mode
        test_mode = 1'b1;
        run(450, 1, 0);

        // R10: back to counter, value resumes
        test_mode = 1'b0;
        src_sel   = 1'b0;
        run(200, 0, 0);

        // mixed random traffic
        run(2000, 1, 1);

        // R1: reset in the middle of operation
        @(negedge clk);
        rst_n     = 1'b0;
        test_mode = 1'b0;
        src_sel   = 1'b0;
        repeat (3) @(negedge clk);
        check_reset();
        rst_n = 1'b1;
        run(100, 0, 0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            summary();
            $finish;
        end
    end

endmodule